// File: doc/BRIEF.md
# Iterative Decimal (BCD) Multiplier

This block multiplies two unsigned decimal operands of `N` digits each. Every operand digit is a 4-bit binary-coded decimal value. The result is a 2N-digit BCD product. A bank of `N` single-digit multipliers forms the product of the whole multiplicand and one multiplier digit in each clock cycle. The multiplier digits are taken least significant first. A decimal accumulator adds each partial product to a running sum and then retires one finished product digit per cycle by shifting the sum one decimal place.

Partial-product generation and accumulation sit in two register stages. For this reason the last addition of one product can share a cycle with the first partial product of the next product. A caller that holds `start_i` high gets a new operation accepted every `N` cycles. Each result appears `N+1` cycles after its operands were taken. The result is marked by a one-cycle `done_o` pulse, and the product stays on `product_o` until the next result replaces it. The operands are assumed to be valid BCD, and `N` must be at least 2.

Top module: `bcd_iter_mul`

## Requirements
- R1: When `done_o` pulses, `product_o` holds the decimal product of the multiplicand and multiplier that were accepted for that operation. Digit k of the product is placed at bits [4k+3:4k], with digit 0 being the least significant.
- R2: `ready_o` is high when no operation is in progress. It is also high in the last of the `N` digit cycles of the current operation. It is low otherwise. Operands are taken at a rising edge where `start_i` and `ready_o` are both high.
- R3: A `start_i` sampled while `ready_o` is low has no effect. It causes no extra result and does not change any result.
- R4: `done_o` is high in the cycle that follows the edge `N+1` clock edges after the accepting edge.
- R5: With `start_i` held high, operations are accepted every `N` cycles, and their results arrive every `N` cycles.
- R6: `done_o` is high for exactly one cycle per result. `product_o` changes only on a result and otherwise holds its value.
- R7: Every 4-bit digit of a delivered product is in the range 0 to 9.
- R8: While reset is applied, after a clock edge, `ready_o` is 1, `done_o` is 0 and `product_o` is 0.
- R9: Operands of zero, one and all nines (including all nines times all nines) give exact products.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request to begin a multiplication |
| a_i | input | 4*N | Multiplicand, N BCD digits |
| b_i | input | 4*N | Multiplier, N BCD digits |
| ready_o | output | 1 | A start is accepted in this cycle |
| done_o | output | 1 | One-cycle pulse: a new product is on `product_o` |
| product_o | output | 8*N | Product, 2N BCD digits, held between results |

## Verification
The bench goes after three classes of fault.

**Overlap cycle.** The bench holds the start request high so that each acceptance coincides with the final accumulation of the previous operation. A design that cleared the running sum or the operand registers too early at this point would corrupt either that product or the next one.

**Carry paths.** Operands of all nines drive the longest decimal carry chains in the partial-product and accumulator adders. A missing +6 correction or a dropped carry would produce a wrong digit or a digit above 9.

**Stray starts.** Requests made while the block is busy must not retrigger it. Those cycles are checked for spurious `done_o` pulses. Result timing is checked cycle by cycle against the N+1 latency, so an off-by-one in the sequencer shows up as a misplaced or missing pulse.

// File: rtl/bcd_mul_pkg.sv
// Package: shared BCD types and widths for the iterative decimal multiplier.
// Assumes 4-bit digits encoded 0..9.
package bcd_mul_pkg;
    localparam int DIGIT_W = 4;
    typedef logic [DIGIT_W-1:0] bcd_digit_t;
endpackage

// File: rtl/bcd_digit_mul.sv
// Single-digit decimal multiplier: x*y (0..81) returned as tens and units digits.
// Assumes both inputs are valid BCD digits; purely combinational.
module bcd_digit_mul
    import bcd_mul_pkg::*;
(
    input  bcd_digit_t x_i,
    input  bcd_digit_t y_i,
    output bcd_digit_t tens_o,
    output bcd_digit_t ones_o
);
    logic [7:0] prod;

    // Binary product, then split into decimal tens by threshold compare.
    always_comb begin
        prod   = {4'b0, x_i} * {4'b0, y_i};
        tens_o = '0;
        for (int k = 1; k <= 9; k++) begin
            if (prod >= 8'(10 * k)) tens_o = bcd_digit_t'(k);
        end
        ones_o = bcd_digit_t'(prod - 8'(tens_o) * 8'd10);
    end
endmodule

// File: rtl/bcd_add.sv
// Ripple decimal adder over D digits with +6 correction per digit.
// Assumes BCD inputs; cout_o flags a carry out of the top digit.
module bcd_add #(
    parameter int D = 5
) (
    input  logic [4*D-1:0] a_i,
    input  logic [4*D-1:0] b_i,
    output logic [4*D-1:0] sum_o,
    output logic           cout_o
);
    logic [D:0] carry;
    assign carry[0] = 1'b0;
    assign cout_o   = carry[D];

    for (genvar g = 0; g < D; g++) begin : g_digit
        logic [4:0] raw;
        logic [4:0] fixed;
        // Add one digit pair with incoming carry, correct when above 9.
        always_comb begin
            raw = {1'b0, a_i[4*g +: 4]} + {1'b0, b_i[4*g +: 4]} + {4'b0, carry[g]};
            if (raw > 5'd9) begin
                fixed        = raw + 5'd6;
                carry[g+1]   = 1'b1;
            end else begin
                fixed        = raw;
                carry[g+1]   = 1'b0;
            end
            sum_o[4*g +: 4] = fixed[3:0];
        end
    end
endmodule

// File: rtl/bcd_pp_gen.sv
// Partial-product generator: N-digit multiplicand times one digit, giving N+1 digits.
// Uses N single-digit multipliers; tens are shifted one place and summed with units.
// Assumes BCD inputs; ovf_o can only rise on a fault.
module bcd_pp_gen #(
    parameter int N = 4
) (
    input  logic [4*N-1:0]     a_i,
    input  logic [3:0]         d_i,
    output logic [4*(N+1)-1:0] pp_o,
    output logic               ovf_o
);
    localparam int PW = 4 * (N + 1);

    logic [4*N-1:0] units;
    logic [4*N-1:0] tens;

    for (genvar g = 0; g < N; g++) begin : g_mul
        bcd_digit_mul u_dm (
            .x_i    (a_i[4*g +: 4]),
            .y_i    (d_i),
            .tens_o (tens[4*g +: 4]),
            .ones_o (units[4*g +: 4])
        );
    end

    logic [PW-1:0] units_al;
    logic [PW-1:0] tens_al;
    assign units_al = {4'b0, units};
    assign tens_al  = {tens, 4'b0};

    bcd_add #(.D(N + 1)) u_align_add (
        .a_i    (units_al),
        .b_i    (tens_al),
        .sum_o  (pp_o),
        .cout_o (ovf_o)
    );
endmodule

// File: rtl/bcd_iter_mul.sv
// Iterative N x N digit decimal multiplier, one multiplier digit per cycle.
// Stage 1 registers a partial product; stage 2 accumulates and shifts out a digit.
// The last accumulation overlaps the next operation's first partial product,
// so latency is N+1 cycles and a new start is accepted every N cycles.
// Assumes N >= 2 and BCD operands.
module bcd_iter_mul
    import bcd_mul_pkg::*;
#(
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [4*N-1:0] a_i,
    input  logic [4*N-1:0] b_i,
    output logic           ready_o,
    output logic           done_o,
    output logic [8*N-1:0] product_o
);
    localparam int DW = DIGIT_W * N;
    localparam int PW = DIGIT_W * (N + 1);
    localparam int CW = (N > 1) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    logic [DW-1:0] a_q, b_q;
    logic          gen_active;
    logic [CW-1:0] gcnt;
    logic          accept;

    assign ready_o = !gen_active || (gcnt == LAST);
    assign accept  = start_i && ready_o;

    // Sequencer: load operands on accept, step one multiplier digit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q        <= '0;
            b_q        <= '0;
            gen_active <= 1'b0;
            gcnt       <= '0;
        end else if (accept) begin
            a_q        <= a_i;
            b_q        <= b_i;
            gen_active <= 1'b1;
            gcnt       <= '0;
        end else if (gen_active) begin
            b_q <= {4'b0, b_q[DW-1:4]};
            if (gcnt == LAST) gen_active <= 1'b0;
            else              gcnt       <= gcnt + 1'b1;
        end
    end

    logic [PW-1:0] pp_next;
    logic          pp_ovf;

    bcd_pp_gen #(.N(N)) u_ppgen (
        .a_i   (a_q),
        .d_i   (b_q[3:0]),
        .pp_o  (pp_next),
        .ovf_o (pp_ovf)
    );

    logic [PW-1:0] pp_q;
    logic          pp_vld, pp_first, pp_last;

    // Partial-product stage: register the product with its position flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pp_q     <= '0;
            pp_vld   <= 1'b0;
            pp_first <= 1'b0;
            pp_last  <= 1'b0;
        end else begin
            pp_q     <= pp_next;
            pp_vld   <= gen_active;
            pp_first <= (gcnt == '0);
            pp_last  <= (gcnt == LAST);
        end
    end

    logic [DW-1:0] hi_q, lo_q;
    logic [PW-1:0] acc_addend, acc_sum;
    logic          acc_cout;

    assign acc_addend = pp_first ? '0 : {4'b0, hi_q};

    bcd_add #(.D(N + 1)) u_acc_add (
        .a_i    (pp_q),
        .b_i    (acc_addend),
        .sum_o  (acc_sum),
        .cout_o (acc_cout)
    );

    // Accumulator: add, retire the lowest digit, publish the product on the last step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q      <= '0;
            lo_q      <= '0;
            done_o    <= 1'b0;
            product_o <= '0;
        end else if (pp_vld) begin
            hi_q   <= acc_sum[PW-1:4];
            lo_q   <= {acc_sum[3:0], lo_q[DW-1:4]};
            done_o <= pp_last;
            if (pp_last) product_o <= {acc_sum[PW-1:4], acc_sum[3:0], lo_q[DW-1:4]};
        end else begin
            done_o <= 1'b0;
        end
    end

    // Partial product of N digits by one digit must fit in N+1 digits (R1).
    assert_pp_fits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        gen_active |-> !pp_ovf);

    // Running sum never carries past N+1 digits (R1).
    assert_acc_no_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pp_vld |-> !acc_cout);

    // After an accept the block is busy for the next cycle (R2).
    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !ready_o);

    // Result strobe lasts one cycle (R6).
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // Product only moves together with a result strobe (R6).
    assert_product_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(product_o) |-> done_o);

    for (genvar g = 0; g < 2 * N; g++) begin : g_chk
        // Every delivered digit is a legal decimal digit (R7).
        assert_digit_bcd_R7: assert property (@(posedge clk) disable iff (!rst_n)
            done_o |-> (product_o[4*g +: 4] <= 4'd9));
    end
endmodule

// File: tb/bcd_iter_mul_tb.sv
// Bench: behavioural reference with an integer product queue, compared every cycle.
module bcd_iter_mul_tb;
    localparam int N  = 4;
    localparam int DW = 4 * N;
    localparam int WD_CYCLES = 20000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [DW-1:0]  a = '0, b = '0;
    logic           ready, done;
    logic [2*DW-1:0] product;

    bcd_iter_mul #(.N(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .a_i(a), .b_i(b),
        .ready_o(ready), .done_o(done), .product_o(product)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int tests = 0, fails = 0;
    longint exp_val[$];
    int     exp_due[$];
    string  exp_tag[$];
    bit     m_busy = 0;
    int     m_cnt = 0;
    logic [2*DW-1:0] last_prod = '0;

    function automatic longint from_bcd(logic [DW-1:0] x);
        longint v = 0;
        for (int i = N - 1; i >= 0; i--) v = v * 10 + longint'(x[4*i +: 4]);
        return v;
    endfunction

    function automatic logic [2*DW-1:0] to_bcd(longint v);
        logic [2*DW-1:0] r = '0;
        for (int i = 0; i < 2 * N; i++) begin
            r[4*i +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return r;
    endfunction

    function automatic logic [DW-1:0] rand_bcd();
        logic [DW-1:0] r;
        for (int i = 0; i < N; i++) r[4*i +: 4] = 4'($urandom_range(0, 9));
        return r;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // One cycle at a negedge: check outputs, drive inputs, advance the model.
    task automatic step(bit s, logic [DW-1:0] av, logic [DW-1:0] bv, string tag);
        bit m_ready = !m_busy || (m_cnt == N - 1);
        bit exp_done = (exp_due.size() > 0) && (exp_due[0] == cyc);
        check(done == exp_done, exp_done ? "R4" : "R3", "done timing",
              longint'(done), longint'(exp_done));
        if (exp_done) begin
            logic [2*DW-1:0] e = to_bcd(exp_val[0]);
            string t = exp_tag[0];
            check(product == e, t, "product value", longint'(product), longint'(e));
            for (int i = 0; i < 2 * N; i++)
                if (product[4*i +: 4] > 4'd9)
                    check(0, "R7", "digit range", longint'(product[4*i +: 4]), 9);
            void'(exp_due.pop_front());
            void'(exp_val.pop_front());
            void'(exp_tag.pop_front());
            last_prod = product;
        end else begin
            check(product == last_prod, "R6", "product hold", longint'(product),
                  longint'(last_prod));
        end
        check(ready == m_ready, "R2 R5", "ready", longint'(ready), longint'(m_ready));
        start = s; a = av; b = bv;
        if (s && m_ready) begin
            exp_due.push_back(cyc + N + 2);
            exp_val.push_back(from_bcd(av) * from_bcd(bv));
            exp_tag.push_back(tag);
            m_busy = 1; m_cnt = 0;
        end else if (m_busy) begin
            if (m_cnt == N - 1) m_busy = 0;
            else m_cnt++;
        end
        @(negedge clk);
    endtask

    // Issue one operation at the earliest ready cycle; stray starts meanwhile (R3).
    task automatic run_op(logic [DW-1:0] av, logic [DW-1:0] bv, string tag);
        while (m_busy && m_cnt != N - 1) step(1'b1, rand_bcd(), rand_bcd(), "R3");
        step(1'b1, av, bv, tag);
    endtask

    initial begin
        logic [DW-1:0] nines = {N{4'h9}};
        logic [DW-1:0] one   = DW'(1);
        repeat (3) @(negedge clk);
        check(ready == 1'b1, "R8", "reset ready", longint'(ready), 1);
        check(done == 1'b0, "R8", "reset done", longint'(done), 0);
        check(product == '0, "R8", "reset product", longint'(product), 0);
        rst_n = 1'b1;
        // Corner operands (R9), streamed at the maximum rate.
        run_op('0, '0, "R9");
        run_op(nines, nines, "R9");
        run_op(one, rand_bcd(), "R9");
        run_op(nines, one, "R9");
        run_op('0, nines, "R9");
        run_op(nines, nines, "R9");
        // Back-to-back random operands (R1, R5).
        for (int i = 0; i < 120; i++) run_op(rand_bcd(), rand_bcd(), "R1");
        // Irregular gaps with idle cycles between operations (R1, R2).
        for (int i = 0; i < 40; i++) begin
            int gap = $urandom_range(0, N + 2);
            for (int k = 0; k < gap; k++) step(1'b0, rand_bcd(), rand_bcd(), "R1");
            run_op(rand_bcd(), rand_bcd(), "R1");
        end
        for (int k = 0; k < N + 4; k++) step(1'b0, '0, '0, "R1");
        check(exp_due.size() == 0, "R4", "pending results", exp_due.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL R4 watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule